// File: doc/BRIEF.md
# CAN Status and Error Confinement Tracker

This block holds the status word of a CAN controller and its error-confinement state. A protocol engine drives it with several inputs: a strobe for each successful transmit and each successful receive, a strobe that carries a 3-bit bus error code, the live receive and transmit error counter values, and a pulse each time it sees a run of 11 recessive bits. A CPU writes the status fields and the init bit of the control word. From these inputs the block keeps a last-error code, two sticky success bits, and the warning, error-passive and bus-off flags.

When the transmit error counter passes its ceiling, the block enters bus-off. It forces init high and drops the bus-active indication. The CPU starts recovery by clearing init. The block then counts runs of recessive bits until the full recovery sequence has been seen. At that point it leaves bus-off and sends a one-cycle request to the engine to zero both error counters. Two one-cycle pulses mark status changes and error-flag changes, for use as interrupt sources.

Top module: `can_stat_tracker`

## Requirements
- R1: After reset the outputs read lec=0, tx_ok=0, rx_ok=0, warn=0, err_passive=0, bus_off=0, init=1, bus_active=0, recov_cnt=0, cnt_clr=0, status_chg=0 and error_chg=0.
- R2: An accepted error strobe loads err_code into lec on the next cycle. The codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0 and 6 CRC. A CPU status write loads sr_lec, and 7 is the usual value for it. That value stays until a bus event replaces it. A bus event in the same cycle as a CPU write wins.
- R3: tx_ok and rx_ok are set by tx_done and rx_done and are never cleared by the engine. Only a CPU status write changes them, loading sr_txok and sr_rxok. If a success strobe and a CPU write arrive in the same cycle, the bit ends up 1.
- R4: warn is 1, one cycle after the inputs, while either error counter is at 96 or more.
- R5: err_passive is 1, one cycle after the inputs, while either error counter is at 128 or more.
- R6: A transmit error counter above 255 sets bus_off and init on the next cycle. bus_active is 1 only while both init and bus_off are 0.
- R7: While bus_off is 1, the tx_done, rx_done and err_vld strobes are ignored. lec, tx_ok and rx_ok do not change, and status_chg stays 0.
- R8: Recessive runs count only from the second cycle after init reads 0 during bus-off. A run seen earlier is ignored. Each counted run loads 5 into lec, pulses status_chg and increments recov_cnt.
- R9: CPU writes to init during recovery neither restart nor shorten it. The run count carries on, and bus-off lasts until exactly 128 runs have been counted.
- R10: The 128th run clears bus_off and recov_cnt, and raises cnt_clr for one cycle. bus_off stays 0 in the following cycle even if the counter still reads above 255.
- R11: status_chg pulses for one cycle after each accepted success strobe, error strobe or counted run, and never after a CPU write alone. error_chg pulses in the cycle in which warn or bus_off changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done | input | 1 | Successful transmit strobe |
| rx_done | input | 1 | Successful receive strobe |
| err_vld | input | 1 | Bus error strobe |
| err_code | input | 3 | Error code carried with err_vld |
| rx_err_cnt | input | 8 | Receive error counter value |
| tx_err_cnt | input | 9 | Transmit error counter value |
| rec_run | input | 1 | Run of 11 recessive bits seen |
| sr_wr | input | 1 | CPU status write strobe |
| sr_lec | input | 3 | Error code value written by CPU |
| sr_txok | input | 1 | tx_ok value written by CPU |
| sr_rxok | input | 1 | rx_ok value written by CPU |
| cr_wr | input | 1 | CPU control write strobe |
| cr_init | input | 1 | init value written by CPU |
| lec | output | 3 | Last error code |
| tx_ok | output | 1 | Sticky transmit success |
| rx_ok | output | 1 | Sticky receive success |
| warn | output | 1 | Warning level flag |
| err_passive | output | 1 | Error passive flag |
| bus_off | output | 1 | Bus-off flag |
| init | output | 1 | Init bit |
| bus_active | output | 1 | Bus participation allowed |
| recov_cnt | output | 7 | Recessive runs counted in recovery |
| cnt_clr | output | 1 | Request to zero both error counters |
| status_chg | output | 1 | Status change pulse |
| error_chg | output | 1 | Warning or bus-off change pulse |

## Verification
The assertions take these things about the inputs for granted:
- The engine never strobes err_vld with code 7.
- It zeroes both counters on the cycle after it sees cnt_clr.
- It raises rec_run as a single-cycle pulse.

The stimulus drives only codes 0 to 6 and gives every strobe a single cycle. After the final recovery run it keeps the transmit counter above 255 for one more cycle, as a slow engine would, and only then zeroes it. The init-write checks during recovery use writes that land between runs, never in the same cycle as one.

// File: rtl/can_stat_pkg.sv
// Shared constants and types for the CAN status tracker.
// Assumes: error code width is fixed at 3 bits by the bus protocol.
package can_stat_pkg;
    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_UNSET = 3'd7
    } lec_t;
endpackage

// File: rtl/can_err_conf.sv
// Error confinement flags: warning, error passive and bus-off.
// Assumes: the engine zeroes its counters the cycle after cnt_clr, so
// bus-off entry is blocked while cnt_clr is high.
module can_err_conf #(
    parameter int REC_W    = 8,
    parameter int TEC_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int TEC_MAX  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REC_W-1:0] rec_cnt,
    input  logic [TEC_W-1:0] tec_cnt,
    input  logic             recov_done,
    input  logic             cnt_clr,
    output logic             ewarn,
    output logic             epass,
    output logic             boff,
    output logic             boff_enter,
    output logic             err_chg
);
    localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIM);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_TOP  = TEC_W'(TEC_MAX);

    logic ewarn_n, epass_n, boff_n;

    // Next-state of the three confinement flags.
    always_comb begin
        ewarn_n    = (rec_cnt >= REC_WARN) || (tec_cnt >= TEC_WARN);
        epass_n    = (rec_cnt >= REC_PASS) || (tec_cnt >= TEC_PASS);
        boff_enter = !boff && !cnt_clr && (tec_cnt > TEC_TOP);
        if (boff_enter)
            boff_n = 1'b1;
        else if (recov_done)
            boff_n = 1'b0;
        else
            boff_n = boff;
    end

    // Flag registers and the error-change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ewarn   <= 1'b0;
            epass   <= 1'b0;
            boff    <= 1'b0;
            err_chg <= 1'b0;
        end else begin
            ewarn   <= ewarn_n;
            epass   <= epass_n;
            boff    <= boff_n;
            err_chg <= (ewarn_n != ewarn) || (boff_n != boff);
        end
    end

    AST_PASS_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        epass |-> ewarn); // R5
    AST_BOFF_FROM_TEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boff) |-> $past(tec_cnt > TEC_TOP)); // R6
    AST_BOFF_EXIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boff) |-> $past(recov_done)); // R10
endmodule

// File: rtl/can_boff_recov.sv
// Init bit and bus-off recovery sequencer.
// Assumes: run11 is a one-cycle pulse per run of 11 recessive bits.
// Recovery is armed once init reads 0 in bus-off and then runs to completion.
module can_boff_recov #(
    parameter int RUNS   = 128,
    parameter int RCNT_W = $clog2(RUNS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boff,
    input  logic              boff_enter,
    input  logic              cr_wr,
    input  logic              cr_init,
    input  logic              run11,
    output logic              init,
    output logic [RCNT_W-1:0] recov_cnt,
    output logic              recov_run,
    output logic              recov_done,
    output logic              cnt_clr
);
    localparam logic [RCNT_W-1:0] LAST = RCNT_W'(RUNS - 1);

    logic active;

    // Qualified run and completion strobes.
    always_comb begin
        recov_run  = active && run11;
        recov_done = recov_run && (recov_cnt == LAST);
    end

    // Init bit: bus-off entry overrides a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init <= 1'b1;
        else if (boff_enter)
            init <= 1'b1;
        else if (cr_wr)
            init <= cr_init;
    end

    // Recovery arm flag, run counter and counter-clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            recov_cnt <= '0;
            cnt_clr   <= 1'b0;
        end else begin
            cnt_clr <= recov_done;
            if (recov_done) begin
                active    <= 1'b0;
                recov_cnt <= '0;
            end else begin
                if (boff && !init)
                    active <= 1'b1;
                if (recov_run)
                    recov_cnt <= recov_cnt + 1'b1;
            end
        end
    end

    AST_INIT_ON_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boff) |-> init); // R6
    AST_CLR_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boff) |-> cnt_clr); // R10
    AST_CNT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(recov_cnt) |-> ($past(active) && $past(boff))); // R9
endmodule

// File: rtl/can_stat_flags.sv
// Status word: last error code, sticky success bits, status-change pulse.
// Assumes: err_code is never 7 when err_vld is high.
module can_stat_flags
    import can_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_evt,
    input  logic       rx_evt,
    input  logic       err_vld,
    input  logic [2:0] err_code,
    input  logic       recov_run,
    input  logic       boff,
    input  logic       sr_wr,
    input  logic [2:0] sr_lec,
    input  logic       sr_txok,
    input  logic       sr_rxok,
    output logic [2:0] lec,
    output logic       tx_ok,
    output logic       rx_ok,
    output logic       stat_chg
);
    logic hw_tx, hw_rx, hw_err, hw_lec;

    // Bus strobes are dropped while the controller is bus-off.
    always_comb begin
        hw_tx  = tx_evt && !boff;
        hw_rx  = rx_evt && !boff;
        hw_err = err_vld && !boff;
        hw_lec = hw_err || recov_run;
    end

    // Status registers: engine events take precedence over CPU writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lec      <= LEC_NONE;
            tx_ok    <= 1'b0;
            rx_ok    <= 1'b0;
            stat_chg <= 1'b0;
        end else begin
            if (recov_run)
                lec <= LEC_BIT0;
            else if (hw_err)
                lec <= err_code;
            else if (sr_wr)
                lec <= sr_lec;
            if (hw_tx)
                tx_ok <= 1'b1;
            else if (sr_wr)
                tx_ok <= sr_txok;
            if (hw_rx)
                rx_ok <= 1'b1;
            else if (sr_wr)
                rx_ok <= sr_rxok;
            stat_chg <= hw_tx || hw_rx || hw_lec;
        end
    end

    AST_HW_LEC_NOT7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lec |=> (lec != LEC_UNSET)); // R2
    AST_TXOK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok && !sr_wr) |=> tx_ok); // R3
    AST_RXOK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && !sr_wr) |=> rx_ok); // R3
    AST_BOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (boff && !sr_wr && !recov_run) |=> ($stable(lec) && !stat_chg)); // R7
endmodule

// File: rtl/can_stat_tracker.sv
// Top: CAN status word and error confinement tracker.
// Assumes: counters come from the protocol engine and are zeroed by it one
// cycle after cnt_clr; all strobes are single-cycle pulses.
module can_stat_tracker #(
    parameter int REC_W    = 8,
    parameter int TEC_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int TEC_MAX  = 255,
    parameter int RUNS     = 128,
    parameter int RCNT_W   = $clog2(RUNS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              err_vld,
    input  logic [2:0]        err_code,
    input  logic [REC_W-1:0]  rx_err_cnt,
    input  logic [TEC_W-1:0]  tx_err_cnt,
    input  logic              rec_run,
    input  logic              sr_wr,
    input  logic [2:0]        sr_lec,
    input  logic              sr_txok,
    input  logic              sr_rxok,
    input  logic              cr_wr,
    input  logic              cr_init,
    output logic [2:0]        lec,
    output logic              tx_ok,
    output logic              rx_ok,
    output logic              warn,
    output logic              err_passive,
    output logic              bus_off,
    output logic              init,
    output logic              bus_active,
    output logic [RCNT_W-1:0] recov_cnt,
    output logic              cnt_clr,
    output logic              status_chg,
    output logic              error_chg
);
    logic boff_enter, recov_run, recov_done;

    can_err_conf #(
        .REC_W(REC_W), .TEC_W(TEC_W), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .TEC_MAX(TEC_MAX)
    ) u_conf (
        .clk(clk), .rst_n(rst_n), .rec_cnt(rx_err_cnt), .tec_cnt(tx_err_cnt),
        .recov_done(recov_done), .cnt_clr(cnt_clr), .ewarn(warn),
        .epass(err_passive), .boff(bus_off), .boff_enter(boff_enter),
        .err_chg(error_chg)
    );

    can_boff_recov #(.RUNS(RUNS), .RCNT_W(RCNT_W)) u_recov (
        .clk(clk), .rst_n(rst_n), .boff(bus_off), .boff_enter(boff_enter),
        .cr_wr(cr_wr), .cr_init(cr_init), .run11(rec_run), .init(init),
        .recov_cnt(recov_cnt), .recov_run(recov_run),
        .recov_done(recov_done), .cnt_clr(cnt_clr)
    );

    can_stat_flags u_flags (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_done), .rx_evt(rx_done),
        .err_vld(err_vld), .err_code(err_code), .recov_run(recov_run),
        .boff(bus_off), .sr_wr(sr_wr), .sr_lec(sr_lec), .sr_txok(sr_txok),
        .sr_rxok(sr_rxok), .lec(lec), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .stat_chg(status_chg)
    );

    // Bus participation needs both init and bus-off low.
    always_comb bus_active = !init && !bus_off;

    AST_ACTIVE_NOT_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> !bus_active); // R6
endmodule

// File: tb/can_stat_tracker_test.sv
`timescale 1ns/1ps
module can_stat_tracker_test;
    localparam int S_LEC = 0, S_TX = 1, S_RX = 2, S_WARN = 3, S_PASS = 4,
                   S_BOFF = 5, S_INIT = 6, S_RCNT = 7, S_SCHG = 8,
                   S_ECHG = 9, S_CLR = 10, S_BACT = 11;

    typedef struct {
        string req;
        int    sel;
        int    val;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_done = 0, rx_done = 0, err_vld = 0, rec_run = 0;
    logic [2:0] err_code = 0, sr_lec = 0;
    logic [7:0] rx_err_cnt = 0;
    logic [8:0] tx_err_cnt = 0;
    logic sr_wr = 0, sr_txok = 0, sr_rxok = 0, cr_wr = 0, cr_init = 0;
    logic [2:0] lec;
    logic tx_ok, rx_ok, warn, err_passive, bus_off, init, bus_active;
    logic [6:0] recov_cnt;
    logic cnt_clr, status_chg, error_chg;

    exp_t q[$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_stat_tracker uut (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done),
        .err_vld(err_vld), .err_code(err_code), .rx_err_cnt(rx_err_cnt),
        .tx_err_cnt(tx_err_cnt), .rec_run(rec_run), .sr_wr(sr_wr),
        .sr_lec(sr_lec), .sr_txok(sr_txok), .sr_rxok(sr_rxok), .cr_wr(cr_wr),
        .cr_init(cr_init), .lec(lec), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .warn(warn), .err_passive(err_passive), .bus_off(bus_off),
        .init(init), .bus_active(bus_active), .recov_cnt(recov_cnt),
        .cnt_clr(cnt_clr), .status_chg(status_chg), .error_chg(error_chg)
    );

    function automatic int actual(int sel);
        case (sel)
            S_LEC:   return int'(lec);
            S_TX:    return int'(tx_ok);
            S_RX:    return int'(rx_ok);
            S_WARN:  return int'(warn);
            S_PASS:  return int'(err_passive);
            S_BOFF:  return int'(bus_off);
            S_INIT:  return int'(init);
            S_RCNT:  return int'(recov_cnt);
            S_SCHG:  return int'(status_chg);
            S_ECHG:  return int'(error_chg);
            S_CLR:   return int'(cnt_clr);
            default: return int'(bus_active);
        endcase
    endfunction

    // Monitor: pops expected items and compares them between clock edges.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                int a;
                e = q.pop_front();
                a = actual(e.sel);
                n_vec++;
                if (a != e.val) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d",
                             e.req, e.sel, a, e.val);
                end
            end
        end
    end

    task automatic ex(string req, int sel, int val);
        q.push_back('{req, sel, val});
    endtask

    task automatic start();
        @(negedge clk);
        tx_done = 0; rx_done = 0; err_vld = 0; rec_run = 0;
        sr_wr = 0; cr_wr = 0;
    endtask

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic t_idle();         start(); go(); endtask
    task automatic t_tx();           start(); tx_done = 1; go(); endtask
    task automatic t_rx();           start(); rx_done = 1; go(); endtask
    task automatic t_run();          start(); rec_run = 1; go(); endtask
    task automatic t_err(logic [2:0] c);
        start(); err_vld = 1; err_code = c; go();
    endtask
    task automatic t_srw(logic [2:0] l, logic t, logic r);
        start(); sr_wr = 1; sr_lec = l; sr_txok = t; sr_rxok = r; go();
    endtask
    task automatic t_crw(logic i);
        start(); cr_wr = 1; cr_init = i; go();
    endtask
    task automatic t_cnt(int r, int t);
        start(); rx_err_cnt = 8'(r); tx_err_cnt = 9'(t); go();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver: applies stimulus and queues expected values.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        ex("R1", S_LEC, 0); ex("R1", S_TX, 0); ex("R1", S_RX, 0);
        ex("R1", S_WARN, 0); ex("R1", S_PASS, 0); ex("R1", S_BOFF, 0);
        ex("R1", S_INIT, 1); ex("R1", S_RCNT, 0); ex("R1", S_SCHG, 0);
        ex("R1", S_ECHG, 0); ex("R1", S_CLR, 0); ex("R1", S_BACT, 0);

        t_crw(0); ex("R6", S_INIT, 0); ex("R6", S_BACT, 1);
        t_tx();   ex("R3", S_TX, 1); ex("R11", S_SCHG, 1);
        t_idle(); ex("R3", S_TX, 1); ex("R11", S_SCHG, 0);
        t_rx();   ex("R3", S_RX, 1); ex("R11", S_SCHG, 1);
        t_err(3); ex("R2", S_LEC, 3); ex("R11", S_SCHG, 1);
        t_err(6); ex("R2", S_LEC, 6);
        t_srw(7, 0, 0); ex("R2", S_LEC, 7); ex("R3", S_TX, 0);
                        ex("R3", S_RX, 0); ex("R11", S_SCHG, 0);
        t_idle(); ex("R2", S_LEC, 7);
        t_err(1); ex("R2", S_LEC, 1);
        // CPU write colliding with bus events: events win.
        start(); sr_wr = 1; sr_lec = 7; sr_txok = 0; sr_rxok = 0;
        tx_done = 1; err_vld = 1; err_code = 2; go();
        ex("R2", S_LEC, 2); ex("R3", S_TX, 1); ex("R3", S_RX, 0);

        t_cnt(95, 0);  ex("R4", S_WARN, 0);
        t_cnt(96, 0);  ex("R4", S_WARN, 1); ex("R11", S_ECHG, 1);
        t_idle();      ex("R11", S_ECHG, 0);
        t_cnt(0, 127); ex("R4", S_WARN, 1); ex("R5", S_PASS, 0);
        t_cnt(0, 128); ex("R5", S_PASS, 1);
        t_cnt(0, 255); ex("R6", S_BOFF, 0);
        t_cnt(0, 256); ex("R6", S_BOFF, 1); ex("R6", S_INIT, 1);
                       ex("R6", S_BACT, 0); ex("R11", S_ECHG, 1);

        t_srw(0, 0, 0); ex("R7", S_LEC, 0); ex("R7", S_TX, 0);
        t_tx();   ex("R7", S_TX, 0); ex("R7", S_SCHG, 0);
        t_rx();   ex("R7", S_RX, 0); ex("R7", S_SCHG, 0);
        t_err(4); ex("R7", S_LEC, 0); ex("R7", S_SCHG, 0);

        t_run();  ex("R8", S_RCNT, 0); ex("R8", S_LEC, 0); ex("R8", S_SCHG, 0);
        t_crw(0); ex("R8", S_INIT, 0); ex("R8", S_BACT, 0);
        t_idle();
        t_run();  ex("R8", S_RCNT, 1); ex("R8", S_LEC, 5); ex("R8", S_SCHG, 1);
        for (int i = 0; i < 62; i++) begin
            t_run(); ex("R8", S_RCNT, i + 2);
        end
        t_crw(1); ex("R9", S_INIT, 1); ex("R9", S_RCNT, 63); ex("R9", S_BOFF, 1);
        t_run();  ex("R9", S_RCNT, 64);
        t_crw(0); ex("R9", S_RCNT, 64);
        for (int i = 0; i < 63; i++) begin
            t_run(); ex("R9", S_RCNT, i + 65); ex("R9", S_BOFF, 1);
        end
        t_run();  ex("R10", S_BOFF, 0); ex("R10", S_CLR, 1);
                  ex("R10", S_RCNT, 0); ex("R11", S_ECHG, 1); ex("R8", S_LEC, 5);
        t_idle(); ex("R10", S_BOFF, 0); ex("R10", S_CLR, 0); ex("R6", S_BACT, 1);
        t_cnt(0, 0); ex("R4", S_WARN, 0); ex("R5", S_PASS, 0);
                     ex("R11", S_ECHG, 1); ex("R10", S_BOFF, 0);
        t_idle();
        @(negedge clk);
        #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule